// File: doc/BRIEF.md
# Cascadable Latched Serial Angle Port

This block receives a 10-bit angle word from a host controller over a three-wire serial link: a select line, a serial clock and a data line. The word can be read as a position on a full circle split into 1024 equal steps. Bits are shifted in while select is high. When select falls, the word is copied into a holding register that feeds a downstream converter, and a one-cycle update strobe is raised at the same moment. Shifting never disturbs the word that is already held.

A serial data output carries the bit that is leaving the shift register. Several ports can therefore be chained: the output of one feeds the data input of the next, and they all share one select and one clock. The three serial pins are sampled by a faster system clock through synchronizers, and their edges are found in that clock domain.

Top module: `serial_angle_port`

## Requirements
- R1: While reset is high and on the first cycle after it, the held angle, the serial data output and the update strobe are all 0. The internal shift register also starts at 0, and the bits it pushes out show this.
- R2: While select is high, each rising edge of the serial clock shifts the data-input level into bit 0 of a 10-bit shift register. The register moves toward bit 9, so the first bit sent ends up as the MSB of the word.
- R3: Serial clock edges and data-input changes that occur while select is low have no effect on the shift register or on the serial data output.
- R4: While select is high, each falling edge of the serial clock updates the serial data output to the current bit 9 of the shift register. At all other times the output holds its value, and it is always driven to 0 or 1.
- R5: While select stays high, shifting changes neither the held angle nor the update strobe, which stays 0.
- R6: When select falls, the held angle is loaded with the shift register contents, that is the last 10 bits shifted in. A frame shorter than 10 bits keeps older register bits in the upper positions.
- R7: The update strobe is high for exactly one system clock for each falling edge of select, in the same cycle as the new held angle first appears.
- R8: If more than 10 clock edges arrive in one select window, only the last 10 bits are held. The older bits keep leaving on the serial data output in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Serial select, high while a frame is shifted |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out toward the next port in a chain |
| angle_o | output | 10 | Held angle word |
| update_o | output | 1 | One-cycle strobe when angle_o is reloaded |

## Verification
The assertions assume that each serial pin holds its level for more than the synchronizer depth plus one system clock between transitions. They also assume that the data input is stable across every rising edge of the serial clock, so that the synchronized data and clock agree. The stimulus holds every pin level for six system clocks, and it changes data only while the serial clock is low. Under these conditions the one-cycle strobe and the stability of the shift register between edges follow from legal inputs.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int ANGLE_W     = 10;
    localparam int SYNC_DEPTH  = 2;

    // Synchronized pin levels and detected edges in the system clock domain
    typedef struct packed {
        logic sel_lvl;
        logic sel_fall;
        logic sck_rise;
        logic sck_fall;
        logic sdi_lvl;
    } pin_evt_t;

    function automatic logic is_rise(input logic now_v, input logic old_v);
        return now_v & ~old_v;
    endfunction

    function automatic logic is_fall(input logic now_v, input logic old_v);
        return ~now_v & old_v;
    endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sap_edge.sv
module sap_edge
    import sap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_s,
    input  logic     sck_s,
    input  logic     sdi_s,
    output pin_evt_t evt_o
);
    logic sel_d, sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_d <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            sel_d <= sel_s;
            sck_d <= sck_s;
        end
    end

    always_comb begin
        evt_o.sel_lvl  = sel_s;
        evt_o.sel_fall = is_fall(sel_s, sel_d);
        evt_o.sck_rise = is_rise(sck_s, sck_d);
        evt_o.sck_fall = is_fall(sck_s, sck_d);
        evt_o.sdi_lvl  = sdi_s;
    end
endmodule

// File: rtl/sap_shift.sv
module sap_shift
    import sap_pkg::*;
#(
    parameter int WORD_W = ANGLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt_i,
    output logic [WORD_W-1:0] shreg_o,
    output logic              sdo_o
);
    logic do_shift, do_out;

    assign do_shift = evt_i.sel_lvl & evt_i.sck_rise;
    assign do_out   = evt_i.sel_lvl & evt_i.sck_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_o <= '0;
            sdo_o   <= 1'b0;
        end else begin
            if (do_shift) shreg_o <= {shreg_o[WORD_W-2:0], evt_i.sdi_lvl};
            if (do_out)   sdo_o   <= shreg_o[WORD_W-1];
        end
    end

    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
        !(evt_i.sel_lvl && evt_i.sck_rise) |=> $stable(shreg_o)); // R3
    AST_SDO_GATED: assert property (@(posedge clk) disable iff (rst)
        !(evt_i.sel_lvl && evt_i.sck_fall) |=> $stable(sdo_o)); // R4
    AST_SDO_KNOWN: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(sdo_o)); // R4
endmodule

// File: rtl/serial_angle_port.sv
module serial_angle_port
    import sap_pkg::*;
#(
    parameter int WORD_W      = ANGLE_W,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic [WORD_W-1:0] angle_o,
    output logic              update_o
);
    localparam int PINS = 3;

    logic [PINS-1:0]   pins_s;
    pin_evt_t          evt;
    logic [WORD_W-1:0] shreg;

    sap_sync #(.STAGES(SYNC_STAGES), .W(PINS)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sel_i, sck_i, sdi_i}),
        .q_o (pins_s)
    );

    sap_edge i_edge (
        .clk   (clk),
        .rst   (rst),
        .sel_s (pins_s[2]),
        .sck_s (pins_s[1]),
        .sdi_s (pins_s[0]),
        .evt_o (evt)
    );

    sap_shift #(.WORD_W(WORD_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .shreg_o (shreg),
        .sdo_o   (sdo_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            angle_o  <= '0;
            update_o <= 1'b0;
        end else begin
            update_o <= evt.sel_fall;
            if (evt.sel_fall) angle_o <= shreg;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !evt.sel_fall |=> $stable(angle_o)); // R5
    AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (rst)
        update_o |-> angle_o == shreg); // R6
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
        update_o |=> !update_o); // R7
endmodule

// File: tb/test_serial_angle_port.sv
module test_serial_angle_port;
    localparam int W  = 10;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic sdo, upd;
    logic [W-1:0] angle;

    int n_chk = 0, n_fail = 0, upd_cnt = 0;
    logic [W-1:0] m_sh = '0;
    logic [W-1:0] m_hold = '0;
    logic m_sdo = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    serial_angle_port i_serial_angle_port (
        .clk(clk), .rst(rst), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
        .sdo_o(sdo), .angle_o(angle), .update_o(upd)
    );

    always @(posedge clk) if (!rst && upd) upd_cnt <= upd_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sdi = b;
        waitc(HP);
        sck = 1'b1;
        if (sel) m_sh = {m_sh[W-2:0], b};
        waitc(HP);
        sck = 1'b0;
        if (sel) m_sdo = m_sh[W-1];
        waitc(HP);
        chk("R4 sdo", sdo, m_sdo);
        chk("R5 angle held", angle, m_hold);
        chk("R5 no strobe", upd, 0);
    endtask

    task automatic close_frame();
        int c0;
        c0 = upd_cnt;
        sel = 1'b0;
        m_hold = m_sh;
        waitc(HP);
        chk("R6 load", angle, m_hold);
        chk("R7 strobe count", upd_cnt - c0, 1);
    endtask

    task automatic frame(input logic [15:0] w, input int n);
        sel = 1'b1;
        waitc(HP);
        for (int i = n - 1; i >= 0; i--) bit_out(w[i]);
        close_frame();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        waitc(3);
        // R1: reset state
        chk("R1 angle", angle, 0);
        chk("R1 sdo", sdo, 0);
        chk("R1 upd", upd, 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 angle after", angle, 0);
        chk("R1 upd after", upd, 0);

        // R2/R6: corner words and a sweep across the code range
        frame(16'h3FF, W);
        chk("R2 all ones", angle, 16'h3FF);
        frame(16'h000, W);
        chk("R2 zero", angle, 0);
        frame(16'h2AA, W);
        chk("R2 msb first", angle, 16'h2AA);
        frame(16'h155, W);
        chk("R2 alt", angle, 16'h155);
        for (int v = 1; v < 1024; v += 29) begin
            frame(16'(v), W);
            chk("R2 sweep", angle, v);
        end

        // R8: 13 bits, last 10 kept; older bits left via sdo (checked in bit_out)
        frame(16'h1E5B, 13);
        chk("R8 last ten", angle, 16'h1E5B & 16'h3FF);

        // R6: short frame keeps older bits above the new ones
        frame(16'h005, 3);
        chk("R6 short frame", angle, m_sh);

        // R3: clock and data toggled while select is low
        for (int i = 0; i < 6; i++) begin
            sdi = i[0]; waitc(HP); sck = 1'b1; waitc(HP); sck = 1'b0; waitc(HP);
        end
        chk("R3 sdo untouched", sdo, m_sdo);
        sel = 1'b1; waitc(HP);
        close_frame();
        chk("R3 register untouched", angle, m_sh);

        // R2: one data bit per frame, accumulating across frames
        for (int i = 0; i < 4; i++) frame(16'(i & 1), 1);
        chk("R2 accumulate", angle, m_sh);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule